// File: doc/BRIEF.md
# Four-Phase Accumulator Processor Core

This block is a small 8-bit processor built around a single working register (the accumulator). Every instruction takes one instruction cycle of four input clocks. The four clocks always do the same jobs in the same order:

1. Fetch the instruction word addressed by the program counter.
2. Split it into an opcode and an operand.
3. Run the ALU on the operand, or on a data RAM word, together with the working register.
4. Write the result back to the working register, or store the working register to data RAM, and step the program counter.

The program is a fixed constant table inside the core, so the core needs no loader. The only inputs are the clock and an active-low synchronous reset. The outputs form a debug port that shows the working register and the program counter. A system uses it as a tiny sequencer whose state can be watched at the debug port once per instruction cycle.

Top module: `quad_acc_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state has the working register at 0, the program counter at 0 and the phase at fetch. This holds for as long as reset stays low.
- R2: Each instruction takes exactly four clocks. The working register and the program counter change only on the fourth clock (write-back). In the three clocks before it they stay stable.
- R3: An instruction word is 12 bits: opcode in bits [11:8], operand in bits [7:0]. Opcode 1 loads the operand into the working register.
- R4: Opcode 2 adds the operand to the working register, modulo 256.
- R5: Opcode 3 replaces the working register with the bitwise AND of the working register and the operand.
- R6: Opcode 4 adds the data RAM word at address operand[3:0] to the working register, modulo 256.
- R7: Opcode 5 stores the working register into data RAM at address operand[3:0] and leaves the working register unchanged. A later opcode 4 reads the stored value.
- R8: Opcode 0 and opcodes 6 to 15 leave the working register unchanged.
- R9: The program counter advances by one per instruction and wraps from 15 to 0.
- R10: The program at addresses 0 to 15 is: 105, 210, 503, 30F, 403, 507, 1F0, 220, 407, 000, F55, 300, 403, 503, 2FF, 13C (hex).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; four clocks form one instruction cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| dbg_w | output | 8 | Current working register value |
| dbg_pc | output | 4 | Current program counter value |

## Verification
Write-back and the program counter step happen on the same clock. The hardest case is the last program address: its instruction writes the working register on the same edge where the counter wraps to 0. The bench runs past address 15 and checks, in one sample, both the new register value (3C) and the counter at 0. A store followed shortly by a RAM add is also judged by the sum it produces. That sum shows the RAM write from one write-back reached the array before a later execute phase read it.

// File: rtl/qac_pkg.sv
package qac_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_SPLIT = 2'd1,
        PH_EXEC  = 2'd2,
        PH_WB    = 2'd3
    } phase_t;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP  = 4'd0,
        OP_LDI  = 4'd1,
        OP_ADDI = 4'd2,
        OP_ANDI = 4'd3,
        OP_ADDR = 4'd4,
        OP_STW  = 4'd5
    } opcode_t;

    typedef enum logic [1:0] {
        ALU_LOAD = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_AND  = 2'd2,
        ALU_HOLD = 2'd3
    } alu_op_t;

    typedef struct packed {
        alu_op_t alu_op;
        logic    src_ram;
        logic    wr_w;
        logic    wr_ram;
    } ctrl_t;

endpackage

// File: rtl/qac_phase_gen.sv
module qac_phase_gen
    import qac_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase
);

    phase_t phase_d, phase_q;

    always_comb begin
        phase_d = phase_t'(phase_q + 2'd1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_FETCH;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;

    p_phase_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phase_q == phase_t'($past(phase_q) + 2'd1));

endmodule

// File: rtl/qac_decode.sv
module qac_decode
    import qac_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output ctrl_t            ctrl
);

    always_comb begin
        ctrl = '{alu_op: ALU_HOLD, src_ram: 1'b0, wr_w: 1'b0, wr_ram: 1'b0};
        case (opc)
            OP_LDI:  ctrl = '{alu_op: ALU_LOAD, src_ram: 1'b0, wr_w: 1'b1, wr_ram: 1'b0};
            OP_ADDI: ctrl = '{alu_op: ALU_ADD,  src_ram: 1'b0, wr_w: 1'b1, wr_ram: 1'b0};
            OP_ANDI: ctrl = '{alu_op: ALU_AND,  src_ram: 1'b0, wr_w: 1'b1, wr_ram: 1'b0};
            OP_ADDR: ctrl = '{alu_op: ALU_ADD,  src_ram: 1'b1, wr_w: 1'b1, wr_ram: 1'b0};
            OP_STW:  ctrl = '{alu_op: ALU_HOLD, src_ram: 1'b0, wr_w: 1'b0, wr_ram: 1'b1};
            default: ;
        endcase
    end

endmodule

// File: rtl/qac_alu.sv
module qac_alu
    import qac_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_t           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        case (op)
            ALU_LOAD: y = a;
            ALU_ADD:  y = a + b;
            ALU_AND:  y = a & b;
            default:  y = b;
        endcase
    end

endmodule

// File: rtl/quad_acc_core.sv
module quad_acc_core
    import qac_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PC_W      = 4,
    parameter int RAM_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DATA_W-1:0] dbg_w,
    output logic [PC_W-1:0]   dbg_pc
);

    localparam int INSTR_W = OPC_W + DATA_W;
    localparam int RAM_AW  = $clog2(RAM_DEPTH);

    typedef struct packed {
        logic [INSTR_W-1:0] ir;
        logic [OPC_W-1:0]   opc;
        logic [DATA_W-1:0]  opd;
        logic [DATA_W-1:0]  alu;
        logic [DATA_W-1:0]  w;
        logic [PC_W-1:0]    pc;
    } core_st_t;

    function automatic logic [INSTR_W-1:0] rom_word(input logic [PC_W-1:0] addr);
        logic [INSTR_W-1:0] v;
        case (int'(addr))
            0:  v = 12'h105;
            1:  v = 12'h210;
            2:  v = 12'h503;
            3:  v = 12'h30F;
            4:  v = 12'h403;
            5:  v = 12'h507;
            6:  v = 12'h1F0;
            7:  v = 12'h220;
            8:  v = 12'h407;
            9:  v = 12'h000;
            10: v = 12'hF55;
            11: v = 12'h300;
            12: v = 12'h403;
            13: v = 12'h503;
            14: v = 12'h2FF;
            15: v = 12'h13C;
            default: v = '0;
        endcase
        return v;
    endfunction

    phase_t            phase;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] ram_q [RAM_DEPTH];
    logic [DATA_W-1:0] ram_rd;
    logic [DATA_W-1:0] alu_a;
    logic [DATA_W-1:0] alu_y;
    logic [RAM_AW-1:0] ram_addr;
    core_st_t          st_d, st_q;

    qac_phase_gen u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    qac_decode u_dec (
        .opc  (st_q.opc),
        .ctrl (ctrl)
    );

    assign ram_addr = st_q.opd[RAM_AW-1:0];
    assign ram_rd   = ram_q[ram_addr];
    assign alu_a    = ctrl.src_ram ? ram_rd : st_q.opd;

    qac_alu #(.DATA_W(DATA_W)) u_alu (
        .op (ctrl.alu_op),
        .a  (alu_a),
        .b  (st_q.w),
        .y  (alu_y)
    );

    always_comb begin
        st_d = st_q;
        case (phase)
            PH_FETCH: st_d.ir = rom_word(st_q.pc);
            PH_SPLIT: begin
                st_d.opc = st_q.ir[INSTR_W-1:DATA_W];
                st_d.opd = st_q.ir[DATA_W-1:0];
            end
            PH_EXEC:  st_d.alu = alu_y;
            PH_WB: begin
                if (ctrl.wr_w) st_d.w = st_q.alu;
                st_d.pc = st_q.pc + 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst_n && phase == PH_WB && ctrl.wr_ram)
            ram_q[ram_addr] <= st_q.w;
    end

    assign dbg_w  = st_q.w;
    assign dbg_pc = st_q.pc;

    p_w_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_WB) |=> $stable(st_q.w));

    p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_WB) |=> $stable(st_q.pc));

    p_pc_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WB) |=> st_q.pc == PC_W'($past(st_q.pc) + 1'b1));

    p_store_keeps_w_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WB && st_q.opc == OP_STW) |=> $stable(st_q.w));

endmodule

// File: tb/quad_acc_core_tb_top.sv
module quad_acc_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] dbg_w;
    logic [3:0] dbg_pc;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    quad_acc_core dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .dbg_w  (dbg_w),
        .dbg_pc (dbg_pc)
    );

    // expected W after each program word (R10 program, computed by hand)
    localparam logic [7:0] EXP_W [16] = '{
        8'h05, 8'h15, 8'h15, 8'h05, 8'h1A, 8'h1A, 8'hF0, 8'h10,
        8'h2A, 8'h2A, 8'h2A, 8'h00, 8'h15, 8'h15, 8'h14, 8'h3C
    };
    localparam string REQ [16] = '{
        "R3", "R4", "R7", "R5", "R6", "R7", "R3", "R4",
        "R6", "R8", "R8", "R5", "R6", "R7", "R4", "R9"
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_instr(input int idx, input logic [7:0] exp_w);
        logic [7:0] w0;
        logic [3:0] pc0;
        w0  = dbg_w;
        pc0 = dbg_pc;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R2 w stable", dbg_w, w0);
            check("R2 pc stable", {4'h0, dbg_pc}, {4'h0, pc0});
        end
        @(negedge clk);
        check(REQ[idx], dbg_w, exp_w);
        check("R9 pc step", {4'h0, dbg_pc}, {4'h0, 4'(pc0 + 4'd1)});
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 w", dbg_w, 8'h00);
        check("R1 pc", {4'h0, dbg_pc}, 8'h00);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            run_instr(i % 16, EXP_W[i % 16]);
        end
        // mid-instruction reset
        @(negedge clk);
        rst_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R1 w held", dbg_w, 8'h00);
            check("R1 pc held", {4'h0, dbg_pc}, 8'h00);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            run_instr(i, EXP_W[i]);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule